// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block gathers a vector of device interrupt lines into a single pending word and fans it out to a set of processors. Each processor has its own enable mask. The masked pending word for a processor is that processor's mask ANDed with the pending word. The processor's interrupt output is a registered level that is high whenever that masked word has any bit set. Devices report activity through per-line set and clear event vectors. A set marks a line pending; a clear withdraws it.

Software reaches the block through a plain 64-bit register port addressed by byte offset. The register index is the offset shifted right by six. The masks are read/write. The per-CPU masked pending words and the raw pending word are read-only. Every request gets a response one cycle later. The response carries either read data or an error pulse.

The response path is a four-state machine on `rsp_state_q`: `RSP_IDLE`, `RSP_READ`, `RSP_WRITE` and `RSP_ERROR`. Each cycle the next state is chosen from the current request alone, so any state can move to any state:
- no request goes to `RSP_IDLE`;
- an illegal request goes to `RSP_ERROR`;
- a legal write goes to `RSP_WRITE`;
- a legal read goes to `RSP_READ`.

Top module: `dirq_router`

## Requirements
- R1: While `rst_n` is low, and after it rises, all masks and the raw pending word are zero. `cpu_irq`, `rsp_valid` and `rsp_err` are also low.
- R2: A bit set in `line_set` during a clock edge sets that bit of the raw pending word. A bit set in `line_clr` clears it. If both are set for the same line in the same cycle, the line ends up pending.
- R3: A clear event for a line that is not pending leaves the raw pending word unchanged. So does any cycle without events for that line.
- R4: A legal write to mask index c (c = 0..3) replaces that CPU's mask with `req_wdata`. The other masks keep their values.
- R5: `cpu_irq[c]` equals the OR of (mask c AND raw pending) as they stood one clock earlier. This holds for a mask change, a raw set and a raw clear alike.
- R6: Register index = `req_offset >> 6`, and the low six offset bits are ignored. The index map is: 0..3 = mask of CPU 0..3; 4..7 = masked pending of CPU 0..3; 8 = raw pending; 9 and above are unmapped.
- R7: A legal read returns the addressed register as it stood at the request edge. Masked pending returns mask AND raw; raw pending returns the raw word.
- R8: `req_size` gives log2 of the access width in bytes. Only code 3 (eight bytes) is legal; codes 0..2 are rejected.
- R9: A rejected request gives `rsp_err` high for exactly the response cycle and `rsp_rdata` = 0, and changes no mask. A request is rejected if it has a bad size, writes a read-only index, or uses an unmapped index.
- R10: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high. Writes and errors return `rsp_rdata` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | log2 of access width in bytes |
| req_offset | input | 12 | Byte offset of the register |
| req_wdata | input | 64 | Write data |
| line_set | input | 64 | Per-line set events |
| line_clr | input | 64 | Per-line clear events |
| rsp_valid | output | 1 | Response cycle |
| rsp_err | output | 1 | Request rejected |
| rsp_rdata | output | 64 | Read data |
| cpu_irq | output | 4 | Per-CPU device interrupt level |

## Verification
The hardest case to reach is the interplay at a single line between a mask change and a pending change. One example is a mask that gains a bit which is already pending and must raise the interrupt at once. Another is a set and a clear colliding on the same line in the same cycle. The stimulus first loads four deliberately different masks: all ones, alternating bits, the other alternation, and one top bit. It then walks every line through set and clear, so each line meets every mask pattern. Masks are rewritten while lines are pending, and collision and spurious-clear events are aimed at lines whose state is known.

// File: rtl/dirq_pkg.sv
package dirq_pkg;
    typedef enum logic [1:0] {
        RSP_IDLE  = 2'd0,
        RSP_READ  = 2'd1,
        RSP_WRITE = 2'd2,
        RSP_ERROR = 2'd3
    } rsp_state_e;

    typedef enum logic [1:0] {
        KIND_MASK   = 2'd0,
        KIND_MASKED = 2'd1,
        KIND_RAW    = 2'd2,
        KIND_NONE   = 2'd3
    } reg_kind_e;

    localparam logic [1:0] SIZE_DWORD = 2'd3;
    localparam int         IDX_SHIFT  = 6;
endpackage

// File: rtl/dirq_decode.sv
module dirq_decode
    import dirq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12,
    localparam int CPU_W  = $clog2(NUM_CPU),
    localparam int IDX_W  = ADDR_W - IDX_SHIFT
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [1:0]        size,
    input  logic              write,
    output reg_kind_e         kind,
    output logic [CPU_W-1:0]  cpu_idx,
    output logic              legal
);
    logic [IDX_W-1:0] idx;
    int               idx_i;

    always_comb begin
        idx     = offset[ADDR_W-1:IDX_SHIFT];
        idx_i   = int'(idx);
        kind    = KIND_NONE;
        cpu_idx = '0;
        if (idx_i < NUM_CPU) begin
            kind    = KIND_MASK;
            cpu_idx = CPU_W'(idx_i);
        end else if (idx_i < 2 * NUM_CPU) begin
            kind    = KIND_MASKED;
            cpu_idx = CPU_W'(idx_i - NUM_CPU);
        end else if (idx_i == 2 * NUM_CPU) begin
            kind    = KIND_RAW;
        end
        legal = (size == SIZE_DWORD) && (kind != KIND_NONE) &&
                (!write || kind == KIND_MASK);
    end
endmodule

// File: rtl/dirq_pending.sv
module dirq_pending #(
    parameter int LINES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] set_ev,
    input  logic [LINES-1:0] clr_ev,
    output logic [LINES-1:0] raw_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= (raw_q & ~clr_ev) | set_ev;
    end
endmodule

// File: rtl/dirq_cpu_slice.sv
module dirq_cpu_slice #(
    parameter int LINES = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [LINES-1:0] wdata,
    input  logic [LINES-1:0] raw,
    output logic [LINES-1:0] mask_q,
    output logic [LINES-1:0] masked,
    output logic             irq_q
);
    assign masked = mask_q & raw;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '0;
            irq_q  <= 1'b0;
        end else begin
            if (wr_en) mask_q <= wdata;
            irq_q <= |masked;
        end
    end
endmodule

// File: rtl/dirq_router.sv
module dirq_router
    import dirq_pkg::*;
#(
    parameter int NUM_CPU = 4,
    parameter int LINES   = 64,
    parameter int ADDR_W  = 12,
    localparam int CPU_W  = $clog2(NUM_CPU)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic                req_write,
    input  logic [1:0]          req_size,
    input  logic [ADDR_W-1:0]   req_offset,
    input  logic [LINES-1:0]    req_wdata,
    input  logic [LINES-1:0]    line_set,
    input  logic [LINES-1:0]    line_clr,
    output logic                rsp_valid,
    output logic                rsp_err,
    output logic [LINES-1:0]    rsp_rdata,
    output logic [NUM_CPU-1:0]  cpu_irq
);
    reg_kind_e                 dec_kind;
    logic [CPU_W-1:0]          dec_cpu;
    logic                      dec_legal;
    logic [LINES-1:0]          raw_q;
    logic [LINES-1:0]          mask_arr   [NUM_CPU];
    logic [LINES-1:0]          masked_arr [NUM_CPU];
    logic [NUM_CPU*LINES-1:0]  mask_flat;
    rsp_state_e                rsp_state_q, rsp_state_d;
    logic [LINES-1:0]          rdata_q, rdata_d;

    dirq_decode #(.NUM_CPU(NUM_CPU), .ADDR_W(ADDR_W)) u_dec (
        .offset  (req_offset),
        .size    (req_size),
        .write   (req_write),
        .kind    (dec_kind),
        .cpu_idx (dec_cpu),
        .legal   (dec_legal)
    );

    dirq_pending #(.LINES(LINES)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_ev (line_set),
        .clr_ev (line_clr),
        .raw_q  (raw_q)
    );

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
        logic wr_hit;
        assign wr_hit = req_valid && dec_legal && req_write &&
                        (dec_cpu == CPU_W'(c));
        dirq_cpu_slice #(.LINES(LINES)) u_slice (
            .clk    (clk),
            .rst_n  (rst_n),
            .wr_en  (wr_hit),
            .wdata  (req_wdata),
            .raw    (raw_q),
            .mask_q (mask_arr[c]),
            .masked (masked_arr[c]),
            .irq_q  (cpu_irq[c])
        );
        assign mask_flat[c*LINES +: LINES] = mask_arr[c];
    end

    // Next-state and read-data selection
    always_comb begin
        rdata_d = '0;
        if (!req_valid)      rsp_state_d = RSP_IDLE;
        else if (!dec_legal) rsp_state_d = RSP_ERROR;
        else if (req_write)  rsp_state_d = RSP_WRITE;
        else                 rsp_state_d = RSP_READ;
        if (rsp_state_d == RSP_READ) begin
            unique case (dec_kind)
                KIND_MASK:   rdata_d = mask_arr[dec_cpu];
                KIND_MASKED: rdata_d = masked_arr[dec_cpu];
                KIND_RAW:    rdata_d = raw_q;
                KIND_NONE:   rdata_d = '0;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_state_q <= RSP_IDLE;
            rdata_q     <= '0;
        end else begin
            rsp_state_q <= rsp_state_d;
            rdata_q     <= rdata_d;
        end
    end

    // Outputs from state
    always_comb begin
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
        rsp_rdata = '0;
        unique case (rsp_state_q)
            RSP_IDLE:  ;
            RSP_READ:  begin rsp_valid = 1'b1; rsp_rdata = rdata_q; end
            RSP_WRITE: rsp_valid = 1'b1;
            RSP_ERROR: begin rsp_valid = 1'b1; rsp_err = 1'b1; end
        endcase
    end
endmodule

// File: rtl/dirq_router_chk.sv
module dirq_router_chk #(
    parameter int NUM_CPU = 4,
    parameter int LINES   = 64
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     req_valid,
    input logic [LINES-1:0]         line_set,
    input logic [LINES-1:0]         line_clr,
    input logic [LINES-1:0]         raw_q,
    input logic [NUM_CPU*LINES-1:0] mask_flat,
    input logic [NUM_CPU-1:0]       cpu_irq,
    input logic                     rsp_valid,
    input logic                     rsp_err
);
    always_comb begin
        if (!rst_n) begin
            assert_reset_quiet_R1: assert (cpu_irq == '0 && !rsp_valid && raw_q == '0);
        end
    end

    assert_set_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> ((raw_q & $past(line_set)) == $past(line_set)));

    assert_untouched_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |->
        (((raw_q ^ $past(raw_q)) & ~($past(line_set) | $past(line_clr))) == '0));

    for (genvar c = 0; c < NUM_CPU; c++) begin : g_irq
        assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $past(rst_n) |->
            (cpu_irq[c] == |($past(mask_flat[c*LINES +: LINES]) & $past(raw_q))));
    end

    assert_err_no_change_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> ($stable(mask_flat) && rsp_valid));

    assert_rsp_follows_req_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (rsp_valid == $past(req_valid)));
endmodule

bind dirq_router dirq_router_chk #(.NUM_CPU(NUM_CPU), .LINES(LINES)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .line_set  (line_set),
    .line_clr  (line_clr),
    .raw_q     (raw_q),
    .mask_flat (mask_flat),
    .cpu_irq   (cpu_irq),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err)
);

// File: tb/sim_dirq_router.sv
module sim_dirq_router;
    localparam int NC = 4;
    localparam int NL = 64;
    localparam int AW = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [1:0]    req_size = 2'd3;
    logic [AW-1:0] req_offset = '0;
    logic [NL-1:0] req_wdata = '0;
    logic [NL-1:0] line_set = '0;
    logic [NL-1:0] line_clr = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [NL-1:0] rsp_rdata;
    logic [NC-1:0] cpu_irq;

    int vectors = 0;
    int fails   = 0;

    logic [NL-1:0] mask_m [NC];
    logic [NL-1:0] raw_m;
    logic          got_valid, got_err;
    logic [NL-1:0] got_rdata;

    always #5 clk = ~clk;

    dirq_router #(.NUM_CPU(NC), .LINES(NL), .ADDR_W(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
        .line_set(line_set), .line_clr(line_clr), .rsp_valid(rsp_valid),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .cpu_irq(cpu_irq)
    );

    task automatic chk(input string rq, input logic [NL-1:0] act, input logic [NL-1:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    function automatic logic [NC-1:0] exp_irq();
        logic [NC-1:0] e;
        for (int c = 0; c < NC; c++) e[c] = |(mask_m[c] & raw_m);
        return e;
    endfunction

    task automatic bus(input logic wr, input logic [1:0] sz, input int idx,
                       input int low, input logic [NL-1:0] wd);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_size   = sz;
        req_offset = AW'((idx << 6) | low);
        req_wdata  = wd;
        @(negedge clk);
        req_valid  = 1'b0;
        got_valid  = rsp_valid;
        got_err    = rsp_err;
        got_rdata  = rsp_rdata;
        if (wr && sz == 2'd3 && idx < NC) mask_m[idx] = wd;
    endtask

    task automatic ev(input logic [NL-1:0] s, input logic [NL-1:0] c);
        @(negedge clk);
        line_set = s;
        line_clr = c;
        @(negedge clk);
        line_set = '0;
        line_clr = '0;
        raw_m = (raw_m & ~c) | s;
    endtask

    task automatic chk_irq(input string rq);
        @(negedge clk);
        chk(rq, NL'(cpu_irq), NL'(exp_irq()));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog act=running exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        for (int c = 0; c < NC; c++) mask_m[c] = '0;
        raw_m = '0;
        repeat (3) @(negedge clk);
        chk("R1 irq in reset", NL'(cpu_irq), '0);
        chk("R1 rsp_valid in reset", NL'(rsp_valid), '0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", NL'(cpu_irq), '0);
        for (int i = 0; i <= 2 * NC; i++) begin
            bus(1'b0, 2'd3, i, 0, '0);
            chk("R1 register zero after reset", got_rdata, '0);
        end

        // R4 / R6: masks with distinct patterns, low offset bits ignored
        bus(1'b1, 2'd3, 0, 0,    {NL{1'b1}});
        bus(1'b1, 2'd3, 1, 8,    {(NL/2){2'b01}});
        bus(1'b1, 2'd3, 2, 6'h38, {(NL/2){2'b10}});
        bus(1'b1, 2'd3, 3, 6'h3f, {1'b1, {(NL-1){1'b0}}});
        chk("R10 write response valid", NL'(got_valid), 1);
        chk("R10 write rdata zero", got_rdata, '0);
        for (int c = 0; c < NC; c++) begin
            bus(1'b0, 2'd3, c, 6'h10, '0);
            chk("R4 R6 mask readback", got_rdata, mask_m[c]);
            chk("R10 read no error", NL'(got_err), 0);
        end
        @(negedge clk);
        chk("R10 rsp_valid drops", NL'(rsp_valid), 0);

        // Sweep every line through set and clear
        for (int n = 0; n < NL; n++) begin
            ev(NL'(1) << n, '0);
            chk_irq("R2 R5 irq after raw set");
            bus(1'b0, 2'd3, 2 * NC, 0, '0);
            chk("R2 R7 raw readback", got_rdata, raw_m);
            bus(1'b0, 2'd3, NC + (n % NC), 0, '0);
            chk("R7 masked readback", got_rdata, mask_m[n % NC] & raw_m);
            ev('0, NL'(1) << n);
            chk_irq("R2 R5 irq after raw clear");
        end

        // R5: mask write while pending raises, masking off lowers
        ev(NL'(1) << 62, '0);
        chk_irq("R5 line 62 pending");
        bus(1'b1, 2'd3, 3, 0, NL'(1) << 62);
        chk_irq("R5 mask gains pending bit");
        chk("R5 cpu3 raised", NL'(cpu_irq[3]), 1);
        bus(1'b1, 2'd3, 0, 0, '0);
        chk_irq("R5 mask cleared drops irq");
        chk("R5 cpu0 dropped", NL'(cpu_irq[0]), 0);

        // R2: set and clear collide
        ev(NL'(1) << 5, NL'(1) << 5);
        bus(1'b0, 2'd3, 2 * NC, 0, '0);
        chk("R2 set wins over clear", got_rdata, raw_m);
        ev(NL'(1) << 7, NL'(1) << 62);
        bus(1'b0, 2'd3, 2 * NC, 0, '0);
        chk("R2 set and clear different lines", got_rdata, raw_m);

        // R3: spurious clears
        ev('0, NL'(1) << 30);
        bus(1'b0, 2'd3, 2 * NC, 0, '0);
        chk("R3 spurious clear no change", got_rdata, raw_m);
        chk_irq("R3 irq unchanged");

        // R8 / R9: bad sizes on writes and reads
        for (int s = 0; s < 3; s++) begin
            bus(1'b1, 2'(s), 1, 0, 64'h1234);
            chk("R8 R9 bad size write err", NL'(got_err), 1);
            bus(1'b0, 2'd3, 1, 0, '0);
            chk("R9 mask unchanged after bad size", got_rdata, mask_m[1]);
            bus(1'b0, 2'(s), 2 * NC, 0, '0);
            chk("R8 bad size read err", NL'(got_err), 1);
            chk("R9 err rdata zero", got_rdata, '0);
        end
        // R9: writes to read-only indices
        for (int i = NC; i <= 2 * NC; i++) begin
            bus(1'b1, 2'd3, i, 0, {NL{1'b1}});
            chk("R9 read-only write err", NL'(got_err), 1);
            chk("R10 err valid", NL'(got_valid), 1);
        end
        bus(1'b0, 2'd3, 2 * NC, 0, '0);
        chk("R9 raw unchanged after rejected write", got_rdata, raw_m);
        // R6 / R9: unmapped indices
        for (int i = 2 * NC + 1; i < 64; i += 5) begin
            bus(1'b0, 2'd3, i, 0, '0);
            chk("R6 R9 unmapped read err", NL'(got_err), 1);
            bus(1'b1, 2'd3, i, 0, {NL{1'b1}});
            chk("R6 R9 unmapped write err", NL'(got_err), 1);
        end
        for (int c = 0; c < NC; c++) begin
            bus(1'b0, 2'd3, c, 0, '0);
            chk("R9 masks intact", got_rdata, mask_m[c]);
        end
        chk_irq("R5 final irq");

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule